// File: doc/BRIEF.md
# Supply Fault Event Register with Clear-on-Read Alias

This block keeps one byte of sticky supply-fault flags for a power-sourcing controller. Each implemented flag is set on any clock edge where its raw fault input is high, and it stays set until software clears it. Analog fault detection upstream is out of scope. Those detectors simply drive level inputs into this register.

Software reads the flags at either of two addresses. A read at the inspect address (0x0A) leaves the flags unchanged. A read at the clear address (0x0B) returns the same byte and then empties the shared latch, so both addresses show zero afterwards. A registered summary interrupt is the OR of a fixed, non-contiguous subset of the flags. A configuration input can drop the oscillator-fail flag from that subset.

Top module: `supply_evt_reg`

## Requirements
- R1: A synchronous active-high reset clears every flag, drives rd_data to 0 and drives supply_irq to 0.
- R2: An implemented flag (bits 0, 1, 4, 5, 7) sets at the clock edge where its flt_in bit is high. It then stays set through idle cycles and through reads at 0x0A.
- R3: When rd_en is high at an edge with rd_addr equal to 0x0A or 0x0B, rd_data shows the flag byte after that edge. If rd_en is low, or the address is any other value, rd_data becomes 0 at that edge.
- R4: A read at 0x0B returns the flag value held before the edge and clears all flags at that edge. A later read at either address then returns 0.
- R5: When a fault input is high in the same cycle as a read at 0x0B, the fault wins. That flag is set after the edge, so the event is not lost.
- R6: supply_irq is registered. After each edge it equals the OR of flag bits 1, 4, 5 and 7 as they are after that edge.
- R7: While osc_mask is high at an edge, flag bit 1 (oscillator fail) is excluded from supply_irq after that edge. The flag itself stays readable.
- R8: Bits 2, 3 and 6 never set and always read 0. Bit 0 latches and reads back but never drives supply_irq. Bit 5 is the digital-supply undervoltage flag and bit 7 is the thermal-shutdown flag.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rd_en | input | 1 | Read strobe |
| rd_addr | input | 8 | Read address |
| flt_in | input | 8 | Raw fault levels, one per flag bit |
| osc_mask | input | 1 | High removes bit 1 from the summary interrupt |
| rd_data | output | 8 | Registered read data |
| supply_irq | output | 1 | Registered summary interrupt |

## Verification
A flag latch that drops a bit, or clears at the wrong moment, shows up on the next read one cycle later. It also shows on supply_irq at the same edge when the bit belongs to the summary set. A wrong clear decode, or a clear that beats a simultaneous fault, shows up on the read that follows the 0x0B access. A wrong mask or summary subset shows on supply_irq one edge after the flag or mask changes, with no read needed. Bits that should not exist reveal themselves on any read after all inputs have been driven high.

// File: rtl/evt_pkg.sv
package evt_pkg;
  typedef enum logic [1:0] {
    ACC_NONE  = 2'd0,
    ACC_PEEK  = 2'd1,
    ACC_CLEAR = 2'd2
  } acc_e;
endpackage

// File: rtl/evt_decode.sv
module evt_decode
  import evt_pkg::*;
#(
  parameter int              AW        = 8,
  parameter logic [AW-1:0]   PEEK_ADDR = 8'h0A,
  parameter logic [AW-1:0]   CLR_ADDR  = 8'h0B
) (
  input  logic          rd_en,
  input  logic [AW-1:0] rd_addr,
  output acc_e          kind
);
  always_comb begin
    kind = ACC_NONE;
    if (rd_en) begin
      if (rd_addr == PEEK_ADDR)     kind = ACC_PEEK;
      else if (rd_addr == CLR_ADDR) kind = ACC_CLEAR;
    end
  end
endmodule

// File: rtl/evt_latch.sv
module evt_latch #(
  parameter int            DW        = 8,
  parameter logic [DW-1:0] IMPL_MASK = 8'hB3
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [DW-1:0] flt_in,
  input  logic          clr,
  output logic [DW-1:0] flags_q,
  output logic [DW-1:0] flags_nxt
);
  logic [DW-1:0] hits;
  assign hits = flt_in & IMPL_MASK;

  for (genvar i = 0; i < DW; i++) begin : g_bit
    if (IMPL_MASK[i]) begin : g_live
      // new fault outranks the clear (R5)
      assign flags_nxt[i] = hits[i] | (flags_q[i] & ~clr);
      always_ff @(posedge clk) begin
        if (rst) flags_q[i] <= 1'b0;
        else     flags_q[i] <= flags_nxt[i];
      end
    end else begin : g_tied
      assign flags_nxt[i] = 1'b0;
      assign flags_q[i]   = 1'b0;
    end
  end

  a_r2_sticky: assert property (@(posedge clk) disable iff (rst)
    (!clr) |=> ((flags_q & $past(flags_q)) == $past(flags_q)));
  a_r4_clear_empties: assert property (@(posedge clk) disable iff (rst)
    (clr && hits == '0) |=> (flags_q == '0));
  a_r5_fault_wins: assert property (@(posedge clk) disable iff (rst)
    (hits != '0) |=> ((flags_q & $past(hits)) == $past(hits)));
  a_r8_unused_zero: assert property (@(posedge clk) disable iff (rst)
    (flags_q & ~IMPL_MASK) == '0);
endmodule

// File: rtl/evt_summary.sv
module evt_summary #(
  parameter int            DW       = 8,
  parameter logic [DW-1:0] SUM_MASK = 8'hB2,
  parameter int            OSC_BIT  = 1
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [DW-1:0] flags_nxt,
  input  logic          osc_mask,
  output logic          irq_q
);
  logic [DW-1:0] osc_sel;
  logic [DW-1:0] eff_mask;

  always_comb begin
    osc_sel          = '0;
    osc_sel[OSC_BIT] = osc_mask;
  end
  assign eff_mask = SUM_MASK & ~osc_sel;

  always_ff @(posedge clk) begin
    if (rst) irq_q <= 1'b0;
    else     irq_q <= |(flags_nxt & eff_mask);
  end

  a_r7_osc_masked: assert property (@(posedge clk) disable iff (rst)
    (osc_mask && ((flags_nxt & SUM_MASK & ~(DW'(1) << OSC_BIT)) == '0)) |=> !irq_q);
  a_r6_nonsum_silent: assert property (@(posedge clk) disable iff (rst)
    ((flags_nxt & SUM_MASK) == '0) |=> !irq_q);
endmodule

// File: rtl/supply_evt_reg.sv
module supply_evt_reg
  import evt_pkg::*;
#(
  parameter int              DW        = 8,
  parameter int              AW        = 8,
  parameter logic [AW-1:0]   PEEK_ADDR = 8'h0A,
  parameter logic [AW-1:0]   CLR_ADDR  = 8'h0B,
  parameter logic [DW-1:0]   IMPL_MASK = 8'hB3,
  parameter logic [DW-1:0]   SUM_MASK  = 8'hB2,
  parameter int              OSC_BIT   = 1
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          rd_en,
  input  logic [AW-1:0] rd_addr,
  input  logic [DW-1:0] flt_in,
  input  logic          osc_mask,
  output logic [DW-1:0] rd_data,
  output logic          supply_irq
);
  acc_e          kind;
  logic [DW-1:0] flags_q;
  logic [DW-1:0] flags_nxt;
  logic          clr;

  evt_decode #(.AW(AW), .PEEK_ADDR(PEEK_ADDR), .CLR_ADDR(CLR_ADDR)) u_dec (
    .rd_en(rd_en), .rd_addr(rd_addr), .kind(kind));

  assign clr = (kind == ACC_CLEAR);

  evt_latch #(.DW(DW), .IMPL_MASK(IMPL_MASK)) u_latch (
    .clk(clk), .rst(rst), .flt_in(flt_in), .clr(clr),
    .flags_q(flags_q), .flags_nxt(flags_nxt));

  evt_summary #(.DW(DW), .SUM_MASK(SUM_MASK), .OSC_BIT(OSC_BIT)) u_sum (
    .clk(clk), .rst(rst), .flags_nxt(flags_nxt), .osc_mask(osc_mask),
    .irq_q(supply_irq));

  // data captured from the pre-clear flags (R4)
  always_ff @(posedge clk) begin
    if (rst)                  rd_data <= '0;
    else if (kind != ACC_NONE) rd_data <= flags_q;
    else                      rd_data <= '0;
  end

  a_r4_prior_value: assert property (@(posedge clk) disable iff (rst)
    (!rst && kind != ACC_NONE) |=> (rd_data == $past(flags_q)));
  a_r3_idle_zero: assert property (@(posedge clk) disable iff (rst)
    (kind == ACC_NONE) |=> (rd_data == '0));
  a_r1_reset_quiet: assert property (@(posedge clk)
    rst |=> (rd_data == '0 && !supply_irq));
endmodule

// File: tb/supply_evt_reg_test.sv
module supply_evt_reg_test;
  localparam int CLK_PERIOD = 10;

  typedef struct packed {
    logic [7:0] flt;
    logic       rd;
    logic [7:0] addr;
    logic       mask;
    logic [7:0] exp_d;
    logic       exp_i;
    logic [3:0] req;
  } vec_t;

  localparam int NV = 18;
  localparam vec_t VECS [NV] = '{
    '{8'h02, 1'b0, 8'h00, 1'b0, 8'h00, 1'b1, 4'd6}, // R6 osc flag raises irq
    '{8'h00, 1'b1, 8'h0A, 1'b0, 8'h02, 1'b1, 4'd2}, // R2 inspect read keeps flag
    '{8'h00, 1'b1, 8'h0A, 1'b1, 8'h02, 1'b0, 4'd7}, // R7 masked osc
    '{8'h01, 1'b0, 8'h00, 1'b1, 8'h00, 1'b0, 4'd8}, // R8 bit0 not in summary
    '{8'h00, 1'b1, 8'h0B, 1'b1, 8'h03, 1'b0, 4'd4}, // R4 clear read returns prior
    '{8'h00, 1'b1, 8'h0A, 1'b0, 8'h00, 1'b0, 4'd4}, // R4 both aliases empty
    '{8'h5C, 1'b0, 8'h00, 1'b0, 8'h00, 1'b1, 4'd8}, // R8 unused bits ignored
    '{8'h00, 1'b1, 8'h0A, 1'b0, 8'h10, 1'b1, 4'd8}, // R8 only bit4 kept
    '{8'h80, 1'b1, 8'h0B, 1'b0, 8'h10, 1'b1, 4'd5}, // R5 fault beats clear
    '{8'h00, 1'b1, 8'h0A, 1'b0, 8'h80, 1'b1, 4'd5}, // R5 thermal kept
    '{8'h00, 1'b1, 8'h0B, 1'b0, 8'h80, 1'b0, 4'd4}, // R4 clear again
    '{8'h00, 1'b1, 8'h0A, 1'b0, 8'h00, 1'b0, 4'd4}, // R4 empty after clear
    '{8'h20, 1'b1, 8'h0C, 1'b0, 8'h00, 1'b1, 4'd3}, // R3 other address reads 0
    '{8'h00, 1'b0, 8'h0A, 1'b0, 8'h00, 1'b1, 4'd3}, // R3 no strobe reads 0
    '{8'h00, 1'b1, 8'h0A, 1'b0, 8'h20, 1'b1, 4'd2}, // R2 uvlo flag held
    '{8'hFF, 1'b0, 8'h00, 1'b0, 8'h00, 1'b1, 4'd8}, // R8 all inputs high
    '{8'h00, 1'b1, 8'h0A, 1'b0, 8'hB3, 1'b1, 4'd8}, // R8 implemented set only
    '{8'h00, 1'b1, 8'h0B, 1'b0, 8'hB3, 1'b0, 4'd4}  // R4 full clear
  };

  logic       clk = 1'b0;
  logic       rst;
  logic       rd_en;
  logic [7:0] rd_addr;
  logic [7:0] flt_in;
  logic       osc_mask;
  logic [7:0] rd_data;
  logic       supply_irq;

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  supply_evt_reg uut (
    .clk(clk), .rst(rst), .rd_en(rd_en), .rd_addr(rd_addr),
    .flt_in(flt_in), .osc_mask(osc_mask),
    .rd_data(rd_data), .supply_irq(supply_irq));

  task automatic check_d(input string req, input logic [7:0] exp);
    checks++;
    if (rd_data !== exp) begin
      errors++;
      $display("FAIL %s rd_data actual %02h expected %02h", req, rd_data, exp);
    end
  endtask

  task automatic check_i(input string req, input logic exp);
    checks++;
    if (supply_irq !== exp) begin
      errors++;
      $display("FAIL %s supply_irq actual %0b expected %0b", req, supply_irq, exp);
    end
  endtask

  // inputs set after a falling edge; one rising edge; sample at next falling edge
  task automatic step(input logic [7:0] f, input logic r, input logic [7:0] a,
                      input logic m);
    flt_in = f; rd_en = r; rd_addr = a; osc_mask = m;
    @(negedge clk);
  endtask

  initial begin
    rst = 1'b1; rd_en = 1'b0; rd_addr = '0; flt_in = '0; osc_mask = 1'b0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    check_d("R1", 8'h00);
    check_i("R1", 1'b0);

    for (int i = 0; i < NV; i++) begin
      step(VECS[i].flt, VECS[i].rd, VECS[i].addr, VECS[i].mask);
      check_d($sformatf("R%0d vec%0d", VECS[i].req, i), VECS[i].exp_d);
      check_i($sformatf("R%0d vec%0d", VECS[i].req, i), VECS[i].exp_i);
    end

    // R7 mask toggled with no read
    step(8'h02, 1'b0, 8'h00, 1'b1);
    check_i("R7 masked", 1'b0);
    step(8'h00, 1'b0, 8'h00, 1'b0);
    check_i("R7 unmasked", 1'b1);
    step(8'h00, 1'b1, 8'h0B, 1'b0);
    check_d("R4 osc clear", 8'h02);
    check_i("R6 after clear", 1'b0);

    // R1 reset mid-state
    step(8'h80, 1'b0, 8'h00, 1'b0);
    check_i("R6 thermal", 1'b1);
    rst = 1'b1;
    step(8'h00, 1'b1, 8'h0A, 1'b0);
    check_d("R1 reset data", 8'h00);
    check_i("R1 reset irq", 1'b0);
    rst = 1'b0;
    step(8'h00, 1'b1, 8'h0A, 1'b0);
    check_d("R1 flags cleared", 8'h00);
    check_i("R1 irq stays low", 1'b0);

    if (!done) begin
      done = 1'b1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    #(CLK_PERIOD * 5000);
    if (!done) begin
      done = 1'b1;
      checks++;
      errors++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule